// File: doc/BRIEF.md
# Transmit Completion Ring Poster

This block reports finished packet transmissions to host software. Each time the transmit side completes a packet, it offers a completion event carrying the 8-bit channel index that sent it. The block queues the event and then writes one 32-bit entry into a 256-slot ring in host memory. That entry carries a host-ownership flag and the channel index. Writes go out one word at a time on a valid/ready request port. The ring base address comes from a configuration input.

The block keeps the ring write pointer internally and shows it on a plain status output, so software can read it back and realign its own consumer index. The pointer moves only when memory accepts a write. A four-deep queue absorbs back-to-back completions while a write is stalled.

Back-pressure rules:
- Event port: an event is taken on a rising edge where `evt_valid` and `evt_ready` are both high. `evt_ready` is low only while the queue is full.
- Write port: a write is taken on a rising edge where `mw_valid` and `mw_ready` are both high. Once `mw_valid` is raised, it stays high with address and data unchanged until the write is taken.

Top module: `txc_ring_poster`

## Requirements
- R1: After synchronous reset, `ring_ptr` is 0, `mw_valid` is 0 and `evt_ready` is 1.
- R2: Every write word has bit 31 set to 1 (owned by host), bits 30:8 zero, and bits 7:0 equal to the channel index of the event it reports.
- R3: The write address equals `ring_base` plus four times the current `ring_ptr`.
- R4: `ring_ptr` increases by exactly one on each accepted write and holds its value in every other cycle.
- R5: `ring_ptr` wraps from 255 to 0, so the write that follows slot 255 targets `ring_base` plus 0.
- R6: Each accepted event produces exactly one write, and writes leave in the order their events were accepted.
- R7: While writes are stalled, four events are accepted and `evt_ready` then drops to 0. An event offered while `evt_ready` is 0 is not queued and produces no write.
- R8: While `mw_valid` is 1 and `mw_ready` is 0, the next cycle keeps `mw_valid` at 1 with `mw_addr` and `mw_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_valid | input | 1 | Completion event offered |
| evt_ready | output | 1 | Queue can take an event |
| evt_chan | input | 8 | Channel index of the completed packet |
| ring_base | input | 32 | Byte address of ring slot 0 |
| mw_valid | output | 1 | Memory write request pending |
| mw_ready | input | 1 | Memory accepts the write |
| mw_addr | output | 32 | Byte address of the write |
| mw_data | output | 32 | Completion entry word |
| ring_ptr | output | 8 | Current ring slot, readable by host |

## Verification
The hold check on the write port assumes `ring_base` does not change while a write is pending, because the address is derived from it combinationally. The bench sets the base once, before any event, and never changes it. The bench also offers events only at the falling edge and observes the ready handshake from there. In this way the queue never sees a push at the same edge as a full condition it did not flag.

// File: rtl/txc_pkg.sv
package txc_pkg;
  localparam int ADDR_W    = 32;
  localparam int DATA_W    = 32;
  localparam int CHAN_W    = 8;
  localparam int SLOT_W    = 8;
  localparam int BYTE_SH   = 2;
  localparam int OWN_POS   = DATA_W - 1;
  localparam int PAD_W     = DATA_W - 1 - CHAN_W;

  function automatic logic [DATA_W-1:0] make_entry(input logic [CHAN_W-1:0] chan);
    return {1'b1, {PAD_W{1'b0}}, chan};
  endfunction
endpackage

// File: rtl/txc_evt_fifo.sv
module txc_evt_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);
  localparam logic [CW-1:0] CAP  = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [IW-1:0] wr_i, rd_i;
  logic [CW-1:0] cnt;

  assign empty = (cnt == '0);
  assign full  = (cnt == CAP);
  assign dout  = mem[rd_i];

  always_ff @(posedge clk) begin
    if (push) mem[wr_i] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_i <= '0;
      rd_i <= '0;
      cnt  <= '0;
    end else begin
      if (push) wr_i <= (wr_i == LAST) ? '0 : wr_i + IW'(1);
      if (pop)  rd_i <= (rd_i == LAST) ? '0 : rd_i + IW'(1);
      case ({push, pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    full |-> !push); // R7
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    empty |-> !pop); // R6
endmodule

// File: rtl/txc_slot_ptr.sv
module txc_slot_ptr
  import txc_pkg::*;
#(
  parameter int PW = SLOT_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic [AW-1:0] base,
  output logic [PW-1:0] slot,
  output logic [AW-1:0] addr
);
  always_ff @(posedge clk) begin
    if (rst)       slot <= '0;
    else if (step) slot <= slot + PW'(1);
  end

  assign addr = base + AW'({slot, {BYTE_SH{1'b0}}});

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    step |=> slot == PW'($past(slot) + PW'(1))); // R5
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(slot)); // R4
endmodule

// File: rtl/txc_ring_poster.sv
module txc_ring_poster
  import txc_pkg::*;
#(
  parameter int QDEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_valid,
  output logic              evt_ready,
  input  logic [CHAN_W-1:0] evt_chan,
  input  logic [ADDR_W-1:0] ring_base,
  output logic              mw_valid,
  input  logic              mw_ready,
  output logic [ADDR_W-1:0] mw_addr,
  output logic [DATA_W-1:0] mw_data,
  output logic [SLOT_W-1:0] ring_ptr
);
  logic              q_empty, q_full, push, take;
  logic [CHAN_W-1:0] q_head;

  assign evt_ready = !q_full;
  assign push      = evt_valid && evt_ready;
  assign mw_valid  = !q_empty;
  assign take      = mw_valid && mw_ready;
  assign mw_data   = make_entry(q_head);

  txc_evt_fifo #(.W(CHAN_W), .DEPTH(QDEPTH)) u_queue (
    .clk(clk), .rst(rst), .push(push), .din(evt_chan),
    .pop(take), .dout(q_head), .empty(q_empty), .full(q_full)
  );

  txc_slot_ptr #(.PW(SLOT_W), .AW(ADDR_W)) u_slot (
    .clk(clk), .rst(rst), .step(take), .base(ring_base),
    .slot(ring_ptr), .addr(mw_addr)
  );

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mw_valid && !mw_ready) |=> mw_valid && $stable(mw_addr) && $stable(mw_data)); // R8
  AST_ENTRY_FMT: assert property (@(posedge clk) disable iff (rst)
    mw_valid |-> mw_data[OWN_POS] && (mw_data[DATA_W-2:CHAN_W] == '0)); // R2
  AST_RESET_STATE: assert property (@(posedge clk)
    $past(rst) |-> (ring_ptr == '0) && !mw_valid && evt_ready); // R1
endmodule

// File: tb/txc_ring_poster_test.sv
`timescale 1ns/1ps
module txc_ring_poster_test;
  logic clk = 0, rst = 1;
  logic evt_valid = 0, mw_ready = 0;
  logic [7:0] evt_chan = 0;
  logic [31:0] ring_base = 32'h1000_0400;
  logic evt_ready, mw_valid;
  logic [31:0] mw_addr, mw_data;
  logic [7:0] ring_ptr;
  int checks = 0, fails = 0;
  logic [7:0] exp_ptr = 0;

  always #2.5 clk = ~clk;

  txc_ring_poster uut (
    .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_chan(evt_chan), .ring_base(ring_base), .mw_valid(mw_valid),
    .mw_ready(mw_ready), .mw_addr(mw_addr), .mw_data(mw_data), .ring_ptr(ring_ptr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic offer(input logic [7:0] c);
    @(negedge clk); evt_valid = 1; evt_chan = c;
    @(negedge clk); evt_valid = 0;
  endtask

  // checks the pending write, accepts it, checks pointer advance
  task automatic accept_one(input logic [7:0] c, input string req);
    @(negedge clk);
    chk({req, " valid"}, {31'd0, mw_valid}, 32'd1);
    chk({req, " data"}, mw_data, {1'b1, 23'd0, c});
    chk({req, " addr"}, mw_addr, ring_base + {22'd0, exp_ptr, 2'b00});
    mw_ready = 1;
    @(negedge clk); mw_ready = 0;
    exp_ptr = exp_ptr + 8'd1;
    chk("R4 step", {24'd0, ring_ptr}, {24'd0, exp_ptr});
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 ptr", {24'd0, ring_ptr}, 0);
    chk("R1 valid", {31'd0, mw_valid}, 0);
    chk("R1 ready", {31'd0, evt_ready}, 1);
  endtask

  task automatic t_single_stall;
    logic [31:0] a0, d0;
    offer(8'h3C);
    chk("R2 data", mw_data, 32'h8000_003C);
    chk("R3 addr", mw_addr, 32'h1000_0400);
    a0 = mw_addr; d0 = mw_data;
    repeat (3) @(negedge clk);
    chk("R8 valid held", {31'd0, mw_valid}, 1);
    chk("R8 addr held", mw_addr, a0);
    chk("R8 data held", mw_data, d0);
    chk("R4 hold", {24'd0, ring_ptr}, 0);
    accept_one(8'h3C, "R2");
    chk("R6 single write", {31'd0, mw_valid}, 0);
  endtask

  task automatic t_fill_and_drain;
    for (int i = 0; i < 4; i++) offer(8'hA0 + 8'(i));
    chk("R7 full", {31'd0, evt_ready}, 0);
    offer(8'h55); // refused while full
    for (int i = 0; i < 4; i++) accept_one(8'hA0 + 8'(i), "R6");
    @(negedge clk);
    chk("R7 refused event dropped", {31'd0, mw_valid}, 0);
    chk("R7 ready back", {31'd0, evt_ready}, 1);
  endtask

  task automatic t_wrap;
    while (exp_ptr != 8'd255) begin
      offer(exp_ptr);
      accept_one(exp_ptr, "R3");
    end
    offer(8'h7E);
    chk("R5 last slot addr", mw_addr, 32'h1000_07FC);
    accept_one(8'h7E, "R5");
    chk("R5 ptr wrapped", {24'd0, ring_ptr}, 0);
    offer(8'h11);
    chk("R5 addr after wrap", mw_addr, 32'h1000_0400);
    accept_one(8'h11, "R5");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    t_reset();
    t_single_stall();
    t_fill_and_drain();
    t_wrap();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule